// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether a received frame should be kept, based only on its 48-bit destination address. The MAC hands the address over as one parallel word on a valid/ready stream. One cycle after the address is taken, the block returns a single keep/drop verdict on a second valid/ready stream. The verdict rests on four checks: an exact match against a programmed station address, recognition of the all-ones broadcast address, a 64-bin multicast hash table, and a promiscuous mode that keeps every unicast frame.

Software programs the filter through a plain write port with five registers:

| Select | Contents |
|---|---|
| 0 | Low four station-address bytes |
| 1 | High two station-address bytes |
| 2 | Hash register A |
| 3 | Hash register B |
| 4 | Four accept-enable bits |

The multicast bin is picked by the top six bits of a CRC-32 taken over the destination bytes. A build-time parameter selects an alternate layout of the hash table, in which the two hash registers trade halves and each register has its bytes reversed.

Back-pressure works as follows. `in_ready` is high whenever the output slot is empty or is being emptied in the same cycle (`out_ready` high). While a verdict waits with `out_ready` low, the verdict holds steady and no new address is taken. Register writes are not subject to back-pressure.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. All registers read as zero, so every address, broadcast included, is dropped until software enables a check.
- R2: An address taken at a clock edge (`in_valid` and `in_ready` both high) produces `out_valid`=1 with its verdict right after that edge. While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and `out_accept` holds its value.
- R3: With enable bit 0 of the configuration register set, a unicast address equal to the station address is kept. Destination byte 0 is `in_dst[47:40]` and byte 5 is `in_dst[7:0]`. Station bytes 0..3 sit in select 0 at bits [7:0], [15:8], [23:16] and [31:24]. Station bytes 4..5 sit in select 1 at bits [7:0] and [15:8].
- R4: The all-ones address counts as broadcast. It is kept exactly when enable bit 1 is set, whatever the hash table and the multicast enable hold.
- R5: A non-broadcast address with bit 0 of byte 0 set (`in_dst[40]`) is multicast. Its bin is the top six bits of a CRC-32 with polynomial 0x04C11DB7, initial value all ones and no final inversion. The CRC is fed byte 0 first, and each byte least significant bit first. In the default layout, bins 0..31 are bits of hash register A and bins 32..63 are bits of hash register B.
- R6: A multicast address is kept only when enable bit 2 is set and its bin bit is 1.
- R7: With all ones in both hash registers and enable bit 2 set, every multicast address is kept.
- R8: With enable bit 3 (promiscuous) set, every unicast address is kept, whatever the station address.
- R9: With bit 3 clear, a unicast address that differs from the station address, including one with its bytes reversed, is dropped.
- R10: In the alternate layout (`SWAP_HASH_ORDER`=1), table bits 63..32 are hash register A with its four bytes reversed, and table bits 31..0 are hash register B with its four bytes reversed.
- R11: A register write at a clock edge affects only addresses taken at later edges. An address taken at the same edge is judged with the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0..4) |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Destination address valid |
| in_dst | input | 48 | Destination address, byte 0 in the top bits |
| in_ready | output | 1 | Filter can take an address |
| out_ready | input | 1 | Consumer takes the verdict |
| out_valid | output | 1 | Verdict valid |
| out_accept | output | 1 | 1 = keep frame, 0 = drop |

## Verification
Every verdict is due one edge after its address is taken. The bench drives inputs on falling edges and samples the verdict at the following falling edge, after exactly one rising edge. During a stall it samples at each falling edge that the verdict and `in_ready` stay fixed. It also samples that the waiting address is taken at the first rising edge after `out_ready` rises, with its verdict on the falling edge after that. Register writes are likewise applied on one falling edge and count from the next rising edge. One check places a write and an address on the same edge to show the old contents are used.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int REG_W  = 32;
  localparam int MAC_W  = 48;
  localparam int NBYTE  = MAC_W / 8;
  localparam int HASH_W = $clog2(2 * REG_W);
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  localparam logic [2:0] SEL_STA_LO = 3'd0;
  localparam logic [2:0] SEL_STA_HI = 3'd1;
  localparam logic [2:0] SEL_HASH_A = 3'd2;
  localparam logic [2:0] SEL_HASH_B = 3'd3;
  localparam logic [2:0] SEL_CFG    = 3'd4;

  typedef struct packed {
    logic prom;   // bit 3
    logic mc;     // bit 2
    logic bc;     // bit 1
    logic sta;    // bit 0
  } rx_cfg_t;
endpackage

// File: rtl/rx_hash_index.sv
module rx_hash_index
  import rx_filt_pkg::*;
(
  input  logic [MAC_W-1:0]  dst,
  output logic [HASH_W-1:0] idx
);
  logic [31:0] crc;
  logic        fb;

  always_comb begin
    crc = '1;
    fb  = 1'b0;
    for (int b = 0; b < NBYTE; b++) begin
      for (int i = 0; i < 8; i++) begin
        fb  = crc[31] ^ dst[MAC_W - 8 - 8*b + i];
        crc = {crc[30:0], 1'b0};
        if (fb) crc = crc ^ CRC_POLY;
      end
    end
    idx = crc[31 -: HASH_W];
  end
endmodule

// File: rtl/rx_hash_table.sv
module rx_hash_table
  import rx_filt_pkg::*;
#(
  parameter bit SWAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  reg_a,
  input  logic [REG_W-1:0]  reg_b,
  input  logic [HASH_W-1:0] idx,
  output logic              hit
);
  localparam int RBYTES = REG_W / 8;
  logic [2*REG_W-1:0] table_bits;

  generate
    if (SWAP) begin : g_swap
      for (genvar k = 0; k < RBYTES; k++) begin : g_byte
        assign table_bits[2*REG_W-1-8*k -: 8] = reg_a[8*k +: 8];
        assign table_bits[REG_W-1-8*k -: 8]   = reg_b[8*k +: 8];
      end
    end else begin : g_plain
      assign table_bits = {reg_b, reg_a};
    end
  endgenerate

  assign hit = table_bits[idx];

  AST_ALL_ONES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((&reg_a) && (&reg_b)) |-> hit); // R7
endmodule

// File: rtl/rx_addr_decide.sv
module rx_addr_decide
  import rx_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAC_W-1:0] dst,
  input  logic [MAC_W-1:0] station,
  input  rx_cfg_t          cfg,
  input  logic             hash_hit,
  output logic             accept
);
  logic is_bc, is_mc;

  assign is_bc = &dst;
  assign is_mc = dst[MAC_W-8];

  always_comb begin
    if (is_bc)      accept = cfg.bc;
    else if (is_mc) accept = cfg.mc & hash_hit;
    else            accept = (cfg.sta && dst == station) || cfg.prom;
  end

  AST_BCAST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bc && !cfg.bc) |-> !accept); // R4
  AST_MC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mc && !is_bc && !cfg.mc) |-> !accept); // R6
  AST_PROMISC_UNI: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_mc && cfg.prom) |-> accept); // R8
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter bit SWAP_HASH_ORDER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             in_valid,
  input  logic [MAC_W-1:0] in_dst,
  output logic             in_ready,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_accept
);
  logic [REG_W-1:0]  sta_lo, hash_a, hash_b;
  logic [15:0]       sta_hi;
  rx_cfg_t           cfg;
  logic [MAC_W-1:0]  station;
  logic [HASH_W-1:0] idx;
  logic              hit, verdict, in_fire;
  logic              ov_q, acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_lo <= '0; sta_hi <= '0; hash_a <= '0; hash_b <= '0; cfg <= '0;
    end else if (reg_wr) begin
      case (reg_sel)
        SEL_STA_LO: sta_lo <= reg_wdata;
        SEL_STA_HI: sta_hi <= reg_wdata[15:0];
        SEL_HASH_A: hash_a <= reg_wdata;
        SEL_HASH_B: hash_b <= reg_wdata;
        SEL_CFG:    cfg    <= rx_cfg_t'(reg_wdata[3:0]);
        default: ;
      endcase
    end
  end

  assign station = {sta_lo[7:0], sta_lo[15:8], sta_lo[23:16], sta_lo[31:24],
                    sta_hi[7:0], sta_hi[15:8]};

  rx_hash_index u_idx (.dst(in_dst), .idx(idx));

  rx_hash_table #(.SWAP(SWAP_HASH_ORDER)) u_tbl (
    .clk(clk), .rst_n(rst_n), .reg_a(hash_a), .reg_b(hash_b),
    .idx(idx), .hit(hit));

  rx_addr_decide u_dec (
    .clk(clk), .rst_n(rst_n), .dst(in_dst), .station(station),
    .cfg(cfg), .hash_hit(hit), .accept(verdict));

  assign in_ready = !ov_q || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q  <= 1'b0;
      acc_q <= 1'b0;
    end else if (in_fire) begin
      ov_q  <= 1'b1;
      acc_q <= verdict;
    end else if (out_ready) begin
      ov_q  <= 1'b0;
    end
  end

  assign out_valid  = ov_q;
  assign out_accept = acc_q;

  AST_TAKE_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_accept))); // R2
endmodule

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [47:0] in_dst = '0;
  logic        out_ready = 1'b1;
  logic        in_ready0, out_valid0, out_accept0;
  logic        in_ready1, out_valid1, out_accept1;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_lo = '0, m_ha = '0, m_hb = '0;
  logic [15:0] m_hi = '0;
  logic [3:0]  m_cfg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter #(.SWAP_HASH_ORDER(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_dst(in_dst),
    .in_ready(in_ready0), .out_ready(out_ready), .out_valid(out_valid0),
    .out_accept(out_accept0));

  rx_addr_filter #(.SWAP_HASH_ORDER(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_dst(in_dst),
    .in_ready(in_ready1), .out_ready(out_ready), .out_valid(out_valid1),
    .out_accept(out_accept1));

  function automatic logic [5:0] ref_idx(input logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] by = d[47-8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        logic f = c[31] ^ by[i];
        c = c << 1;
        if (f) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c[31:26];
  endfunction

  function automatic logic [31:0] bsw(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic ref_acc(input logic [47:0] d, input bit swap);
    logic [63:0] t;
    logic [47:0] st;
    t  = swap ? {bsw(m_ha), bsw(m_hb)} : {m_hb, m_ha};
    st = {m_lo[7:0], m_lo[15:8], m_lo[23:16], m_lo[31:24], m_hi[7:0], m_hi[15:8]};
    if (d == 48'hFFFF_FFFF_FFFF) return m_cfg[1];
    if (d[40]) return m_cfg[2] & t[ref_idx(d)];
    return (m_cfg[0] && d == st) || m_cfg[3];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (sel)
      3'd0: m_lo = d;
      3'd1: m_hi = d[15:0];
      3'd2: m_ha = d;
      3'd3: m_hb = d;
      3'd4: m_cfg = d[3:0];
      default: ;
    endcase
  endtask

  // Address offered on a falling edge, taken at the next rising edge,
  // verdict sampled on the falling edge after it.
  task automatic send(input logic [47:0] d, input string tag);
    logic e0, e1;
    e0 = ref_acc(d, 1'b0);
    e1 = ref_acc(d, 1'b1);
    @(negedge clk);
    in_dst = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid0 === 1'b1 && out_accept0 === e0, {tag, " u0"},
        {out_valid0, out_accept0}, {1'b1, e0});
    chk(out_valid1 === 1'b1 && out_accept1 === e1, {tag, " u1"},
        {out_valid1, out_accept1}, {1'b1, e1});
  endtask

  task automatic expect_acc(input logic [47:0] d, input logic a0, input logic a1,
                            input string tag);
    chk(ref_acc(d, 1'b0) == a0 && ref_acc(d, 1'b1) == a1, {tag, " model"},
        {ref_acc(d, 1'b0), ref_acc(d, 1'b1)}, {a0, a1});
    send(d, tag);
  endtask

  function automatic logic [47:0] rnd_mc();
    logic [47:0] d = {$urandom, $urandom};
    d[40] = 1'b1;
    if (d == 48'hFFFF_FFFF_FFFF) d[0] = 1'b0;
    return d;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] a, b, st;
    logic [5:0]  ix;
    int unsigned seed;
    bit found;
    seed = $urandom(32'd4711);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(out_valid0 === 1'b0 && in_ready0 === 1'b1, "R1 reset handshake",
        {out_valid0, in_ready0}, 2'b01);
    expect_acc(48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, "R1 broadcast dropped after reset");

    // R3 / R9: station match and byte order
    st = 48'h02_11_22_33_44_55;
    wr(3'd0, 32'h3322_1102);
    wr(3'd1, 32'h0000_5544);
    wr(3'd4, 32'h1);
    expect_acc(st, 1'b1, 1'b1, "R3 station match");
    expect_acc(48'h02_11_22_33_44_56, 1'b0, 1'b0, "R9 near miss");
    expect_acc(48'h54_44_33_22_11_02, 1'b0, 1'b0, "R9 byte reversed");

    // R4: broadcast enable and priority over hash
    wr(3'd4, 32'h2);
    expect_acc(48'hFFFF_FFFF_FFFF, 1'b1, 1'b1, "R4 broadcast kept");
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'h4);
    expect_acc(48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, "R4 broadcast beats hash");
    // R7: all-ones table
    expect_acc(48'h01_00_5E_00_00_01, 1'b1, 1'b1, "R7 all ones multicast");
    send(rnd_mc(), "R7 all ones random multicast");
    // R6: multicast enable gate
    wr(3'd4, 32'h1);
    expect_acc(48'h01_00_5E_00_00_01, 1'b0, 1'b0, "R6 mc enable clear");

    // R5: single bin in default layout
    a  = 48'h33_33_00_00_00_FB;
    ix = ref_idx(a);
    wr(3'd4, 32'h4);
    wr(3'd2, ix < 32 ? (32'h1 << ix) : 32'h0);
    wr(3'd3, ix >= 32 ? (32'h1 << (ix - 32)) : 32'h0);
    chk(ref_acc(a, 1'b0) == 1'b1, "R5 model single bin", ref_acc(a, 1'b0), 1);
    send(a, "R5 single bin hit");
    wr(3'd2, ~m_ha);
    wr(3'd3, ~m_hb);
    expect_acc(a, 1'b0, ref_acc(a, 1'b1), "R5 single bin cleared");

    // R10: alternate layout, reg A byte 0 bit 0 -> table bit 56
    wr(3'd2, 32'h1);
    wr(3'd3, 32'h0);
    found = 1'b0;
    b = '0;
    for (int t = 0; t < 4000 && !found; t++) begin
      b = rnd_mc();
      if (ref_idx(b) == 6'd56) found = 1'b1;
    end
    chk(found, "R10 search for bin 56", found, 1);
    expect_acc(b, 1'b0, 1'b1, "R10 swapped bin 56");

    // R8: promiscuous
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h8);
    expect_acc(48'h00_AB_CD_EF_12_34, 1'b1, 1'b1, "R8 promisc unicast");
    send(rnd_mc(), "R8 promisc multicast with empty table");

    // R2: stall holds verdict and blocks input
    wr(3'd4, 32'h1);
    @(negedge clk);
    out_ready = 1'b0;
    in_dst = st; in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid0 === 1'b1 && out_accept0 === 1'b1, "R2 first verdict",
        {out_valid0, out_accept0}, 2'b11);
    in_dst = 48'h00_00_00_00_00_02;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(in_ready0 === 1'b0 && out_accept0 === 1'b1 && out_valid0 === 1'b1,
          "R2 stall hold", {in_ready0, out_valid0, out_accept0}, 3'b011);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid0 === 1'b1 && out_accept0 === 1'b0, "R2 second verdict after release",
        {out_valid0, out_accept0}, 2'b10);
    @(negedge clk);
    chk(out_valid0 === 1'b0, "R2 drained", out_valid0, 0);

    // R11: write and address on the same edge use old contents
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 3'd4; reg_wdata = 32'h0;
    in_dst = st; in_valid = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; in_valid = 1'b0;
    m_cfg = 4'h0;
    chk(out_accept0 === 1'b1 && out_valid0 === 1'b1, "R11 same edge old cfg",
        {out_valid0, out_accept0}, 2'b11);
    expect_acc(st, 1'b0, 1'b0, "R11 later edge new cfg");

    // Random mix
    for (int it = 0; it < 300; it++) begin
      logic [47:0] d;
      int unsigned r;
      if (it % 10 == 0) begin
        wr(3'd0, $urandom);
        wr(3'd1, $urandom);
        wr(3'd2, $urandom);
        wr(3'd3, $urandom);
        wr(3'd4, $urandom);
      end
      r = $urandom_range(0, 99);
      if (r < 25)
        d = {m_lo[7:0], m_lo[15:8], m_lo[23:16], m_lo[31:24], m_hi[7:0], m_hi[15:8]};
      else if (r < 40) d = 48'hFFFF_FFFF_FFFF;
      else if (r < 70) d = rnd_mc();
      else begin
        d = {$urandom, $urandom};
        d[40] = 1'b0;
      end
      send(d, "R3 R4 R5 R6 R8 R10 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule